// File: doc/BRIEF.md
# Beam Position and Current Calculator

This block turns the four pickup amplitudes of a beam position monitor into a vertical position, a horizontal position and a beam current. The vertical axis uses the normalised difference of channels A and B. The horizontal axis uses channels C and D. Each normalised difference is multiplied by a signed gain, and a calibration offset is then subtracted. The current is the sum of all four amplitudes, multiplied by its own gain, with its offset added.

One iterative divider is shared by both axes. It resolves one quotient bit per clock: the vertical ratio first, then the horizontal ratio. Each accepted input set therefore gives exactly one result pulse a fixed number of cycles later. A small write port loads the three gains and the three offsets.

Upstream logic offers an amplitude set with `in_valid` while `busy` is low. Downstream logic takes the results when `res_valid` pulses.

Top module: `bpos_calc`

## Requirements
- R1: While reset is asserted and right after it: `busy`, `res_valid`, `overrun`, both invalid flags and all three result outputs are zero. All three gains hold 1.0 (16384), and all three offsets hold zero.
- R2: `pos_y` = sat((KY * ry) >>> 14 - YOFS). Here ry = sign(A-B) * floor(|A-B| * 65536 / (A+B)), an 18-bit signed value with 16 fractional bits. The product is taken at full width, and >>> is an arithmetic (floor) shift.
- R3: `pos_x` is formed in the same way from C and D, with gain KX and offset XOFS.
- R4: `beam_cur` = sat((KI * (A+B+C+D)) >>> 14 + IOFS).
- R5: An input set is accepted on a rising edge where `in_valid` is high and `busy` is low. `res_valid` is high for exactly one cycle, following the 39th rising edge after the accepting edge. All result outputs and flags hold their values until the next result.
- R6: When A+B is zero, ry is taken as zero and `y_invalid` is 1 with that result. When C+D is zero, the horizontal ratio is zero and `x_invalid` is 1. Otherwise each flag is 0.
- R7: `busy` is high from the accepting edge until the edge that raises `res_valid`. An `in_valid` seen on any edge while `busy` is high is ignored, and it sets `overrun`. `overrun` then stays high until reset.
- R8: Each result is clamped to the 24-bit signed range [-8388608, 8388607] instead of wrapping.
- R9: A write (`cfg_we` high) to select code 0 loads KY, code 1 loads KX and code 2 loads KI, each from the low 16 bits of `cfg_data` as a signed Q2.14 value. Codes 3, 4 and 5 load YOFS, XOFS and IOFS from all 24 bits. Codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Amplitude set offered |
| amp_a | input | 18 | Channel A amplitude, unsigned |
| amp_b | input | 18 | Channel B amplitude, unsigned |
| amp_c | input | 18 | Channel C amplitude, unsigned |
| amp_d | input | 18 | Channel D amplitude, unsigned |
| cfg_we | input | 1 | Gain/offset write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_data | input | 24 | Write data |
| busy | output | 1 | Calculation in progress |
| res_valid | output | 1 | One-cycle result strobe |
| pos_x | output | 24 | Horizontal position, signed |
| pos_y | output | 24 | Vertical position, signed |
| beam_cur | output | 24 | Beam current, signed |
| x_invalid | output | 1 | C+D was zero for this result |
| y_invalid | output | 1 | A+B was zero for this result |
| overrun | output | 1 | Sticky: an input set was dropped |

## Verification
The hardest case to reach is an input set offered on the edge where the block is just leaving its busy state, in the same cycle the result is produced. Only continuous offering at the exact latency reaches it. The bench holds `in_valid` high across whole calculations and also offers a set on exactly the 39th edge. In both cases its cycle-level model must agree on which set is dropped, when `overrun` rises and which set is taken next. The saturation corners and the zero-sum axes are reached by loading extreme gains and offsets through the write port and driving all-zero or full-scale amplitudes.

// File: rtl/bpos_pkg.sv
`timescale 1ns/1ps
package bpos_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_YGO   = 3'd1,
    ST_YWAIT = 3'd2,
    ST_XGO   = 3'd3,
    ST_XWAIT = 3'd4,
    ST_OUT   = 3'd5
  } calc_state_t;

  localparam int unsigned CFG_SEL_W  = 3;
  localparam int unsigned NUM_GAINS  = 3;  // select codes 0..2
  localparam int unsigned OFS_BASE   = 3;  // select codes 3..5
endpackage

// File: rtl/bpos_cfg.sv
`timescale 1ns/1ps
module bpos_cfg #(
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  parameter int OFS_W     = 24
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [bpos_pkg::CFG_SEL_W-1:0]    sel,
  input  logic [OFS_W-1:0]                  data,
  output logic signed [COEF_W-1:0]          gain_y,
  output logic signed [COEF_W-1:0]          gain_x,
  output logic signed [COEF_W-1:0]          gain_i,
  output logic signed [OFS_W-1:0]           ofs_y,
  output logic signed [OFS_W-1:0]           ofs_x,
  output logic signed [OFS_W-1:0]           ofs_i
);
  import bpos_pkg::*;

  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1) << COEF_FRAC;

  logic signed [COEF_W-1:0] gain_q [NUM_GAINS];
  logic signed [OFS_W-1:0]  ofs_q  [NUM_GAINS];

  for (genvar g = 0; g < NUM_GAINS; g++) begin : g_regs
    logic gain_en, ofs_en;
    assign gain_en = we && (sel == CFG_SEL_W'(g));
    assign ofs_en  = we && (sel == CFG_SEL_W'(OFS_BASE + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_q[g] <= UNITY;
      end else if (gain_en) begin
        gain_q[g] <= data[COEF_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ofs_q[g] <= '0;
      end else if (ofs_en) begin
        ofs_q[g] <= data;
      end
    end
  end

  assign gain_y = gain_q[0];
  assign gain_x = gain_q[1];
  assign gain_i = gain_q[2];
  assign ofs_y  = ofs_q[0];
  assign ofs_x  = ofs_q[1];
  assign ofs_i  = ofs_q[2];

  // R9: unused select codes leave every register untouched
  assert_unused_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel >= CFG_SEL_W'(OFS_BASE + NUM_GAINS)) |=>
      ($stable(gain_q[0]) && $stable(gain_q[1]) && $stable(gain_q[2]) &&
       $stable(ofs_q[0]) && $stable(ofs_q[1]) && $stable(ofs_q[2])));
endmodule

// File: rtl/bpos_divider.sv
`timescale 1ns/1ps
module bpos_divider #(
  parameter int NUM_W = 18,
  parameter int DEN_W = 19,
  parameter int Q_W   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [Q_W-1:0]   quo,
  output logic             done
);
  localparam int REM_W = DEN_W + 1;
  localparam int CNT_W = $clog2(Q_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(Q_W - 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [Q_W-1:0]   quo_q, quo_d;
  logic             done_q, done_d;
  logic [REM_W-1:0] trial;
  logic             fits;

  always_comb begin
    // first step takes the integer bit without shifting
    trial  = (cnt_q == '0) ? rem_q : {rem_q[REM_W-2:0], 1'b0};
    fits   = trial >= REM_W'(den_q);
    run_d  = run_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    den_d  = den_q;
    quo_d  = quo_q;
    done_d = 1'b0;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
      rem_d = REM_W'(num);
      den_d = den;
      quo_d = '0;
    end else if (run_q) begin
      rem_d = fits ? (trial - REM_W'(den_q)) : trial;
      quo_d = {quo_q[Q_W-2:0], fits};
      if (cnt_q == LAST) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      quo_q  <= quo_d;
      done_q <= done_d;
    end
  end

  assign quo  = quo_q;
  assign done = done_q;

  // R5: the shared divider is never restarted mid-division
  assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q);
  // R5: completion is a single-cycle strobe
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/bpos_scale.sv
`timescale 1ns/1ps
module bpos_scale #(
  parameter int IN_W     = 18,
  parameter int COEF_W   = 16,
  parameter int FRAC     = 14,
  parameter int OFS_W    = 24,
  parameter int OUT_W    = 24,
  parameter bit SUBTRACT = 1'b1
) (
  input  logic signed [IN_W-1:0]   val,
  input  logic signed [COEF_W-1:0] gain,
  input  logic signed [OFS_W-1:0]  ofs,
  output logic signed [OUT_W-1:0]  res
);
  localparam int PROD_W = IN_W + COEF_W;
  localparam int ACC_W  = ((PROD_W > OFS_W) ? PROD_W : OFS_W) + 1;
  localparam logic signed [ACC_W-1:0] MAXV =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [PROD_W-1:0] val_x, gain_x, prod, shifted;
  logic signed [ACC_W-1:0]  acc;

  always_comb begin
    val_x   = PROD_W'(val);
    gain_x  = PROD_W'(gain);
    prod    = val_x * gain_x;
    shifted = prod >>> FRAC;
    if (SUBTRACT) begin
      acc = ACC_W'(shifted) - ACC_W'(ofs);
    end else begin
      acc = ACC_W'(shifted) + ACC_W'(ofs);
    end
    if (acc > MAXV) begin
      res = MAXV[OUT_W-1:0];
    end else if (acc < MINV) begin
      res = MINV[OUT_W-1:0];
    end else begin
      res = acc[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/bpos_calc.sv
`timescale 1ns/1ps
module bpos_calc #(
  parameter int AMP_W      = 18,
  parameter int COEF_W     = 16,
  parameter int COEF_FRAC  = 14,
  parameter int OFS_W      = 24,
  parameter int RATIO_FRAC = 16,
  parameter int OUT_W      = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [AMP_W-1:0]         amp_a,
  input  logic [AMP_W-1:0]         amp_b,
  input  logic [AMP_W-1:0]         amp_c,
  input  logic [AMP_W-1:0]         amp_d,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_sel,
  input  logic [OFS_W-1:0]         cfg_data,
  output logic                     busy,
  output logic                     res_valid,
  output logic signed [OUT_W-1:0]  pos_x,
  output logic signed [OUT_W-1:0]  pos_y,
  output logic signed [OUT_W-1:0]  beam_cur,
  output logic                     x_invalid,
  output logic                     y_invalid,
  output logic                     overrun
);
  import bpos_pkg::*;

  localparam int SUM_W = AMP_W + 1;
  localparam int TOT_W = AMP_W + 2;
  localparam int Q_W   = RATIO_FRAC + 1;
  localparam int RAT_W = RATIO_FRAC + 2;
  localparam logic [Q_W-1:0] Q_ONE = Q_W'(1) << RATIO_FRAC;

  calc_state_t state_q, state_d;
  logic [AMP_W-1:0] a_q, b_q, c_q, d_q;
  logic signed [RAT_W-1:0] rat_y_q, rat_y_d, rat_x_q, rat_x_d;
  logic yinv_q, yinv_d, xinv_q, xinv_d;
  logic ovr_q, ovr_d;
  logic res_v_q, res_v_d;
  logic signed [OUT_W-1:0] py_q, px_q, pi_q;
  logic oyinv_q, oxinv_q;

  logic accept, out_en;
  logic [SUM_W-1:0] sum_ab, sum_cd;
  logic [AMP_W-1:0] mag_ab, mag_cd;
  logic neg_y, neg_x;
  logic [TOT_W-1:0] sum_all;
  logic div_start, div_done;
  logic [AMP_W-1:0] div_num;
  logic [SUM_W-1:0] div_den;
  logic [Q_W-1:0]   div_quo;
  logic signed [RAT_W-1:0] quo_s;
  logic signed [OUT_W-1:0] py_n, px_n, pi_n;
  logic signed [COEF_W-1:0] k_y, k_x, k_i;
  logic signed [OFS_W-1:0]  o_y, o_x, o_i;

  // operand preparation from the captured amplitude set
  always_comb begin
    sum_ab  = SUM_W'(a_q) + SUM_W'(b_q);
    sum_cd  = SUM_W'(c_q) + SUM_W'(d_q);
    neg_y   = a_q < b_q;
    neg_x   = c_q < d_q;
    mag_ab  = neg_y ? (b_q - a_q) : (a_q - b_q);
    mag_cd  = neg_x ? (d_q - c_q) : (c_q - d_q);
    sum_all = TOT_W'(sum_ab) + TOT_W'(sum_cd);
  end

  // shared divider operand steering
  always_comb begin
    div_start = (state_q == ST_YGO) || (state_q == ST_XGO);
    div_num   = (state_q == ST_XGO) ? mag_cd : mag_ab;
    div_den   = (state_q == ST_XGO) ? sum_cd : sum_ab;
  end

  bpos_divider #(
    .NUM_W (AMP_W),
    .DEN_W (SUM_W),
    .Q_W   (Q_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .quo   (div_quo),
    .done  (div_done)
  );

  bpos_cfg #(
    .COEF_W    (COEF_W),
    .COEF_FRAC (COEF_FRAC),
    .OFS_W     (OFS_W)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .data   (cfg_data),
    .gain_y (k_y),
    .gain_x (k_x),
    .gain_i (k_i),
    .ofs_y  (o_y),
    .ofs_x  (o_x),
    .ofs_i  (o_i)
  );

  // next-state logic
  always_comb begin
    accept  = in_valid && (state_q == ST_IDLE);
    quo_s   = $signed({1'b0, div_quo});
    state_d = state_q;
    rat_y_d = rat_y_q;
    rat_x_d = rat_x_q;
    yinv_d  = yinv_q;
    xinv_d  = xinv_q;
    ovr_d   = ovr_q || (in_valid && (state_q != ST_IDLE));
    res_v_d = 1'b0;
    out_en  = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_YGO;
      ST_YGO:   state_d = ST_YWAIT;
      ST_YWAIT: if (div_done) begin
        yinv_d  = (sum_ab == '0);
        rat_y_d = (sum_ab == '0) ? '0 : (neg_y ? -quo_s : quo_s);
        state_d = ST_XGO;
      end
      ST_XGO:   state_d = ST_XWAIT;
      ST_XWAIT: if (div_done) begin
        xinv_d  = (sum_cd == '0);
        rat_x_d = (sum_cd == '0) ? '0 : (neg_x ? -quo_s : quo_s);
        state_d = ST_OUT;
      end
      ST_OUT: begin
        res_v_d = 1'b1;
        out_en  = 1'b1;
        state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  bpos_scale #(
    .IN_W (RAT_W), .COEF_W (COEF_W), .FRAC (COEF_FRAC),
    .OFS_W (OFS_W), .OUT_W (OUT_W), .SUBTRACT (1'b1)
  ) u_scale_y (
    .val (rat_y_q), .gain (k_y), .ofs (o_y), .res (py_n)
  );

  bpos_scale #(
    .IN_W (RAT_W), .COEF_W (COEF_W), .FRAC (COEF_FRAC),
    .OFS_W (OFS_W), .OUT_W (OUT_W), .SUBTRACT (1'b1)
  ) u_scale_x (
    .val (rat_x_q), .gain (k_x), .ofs (o_x), .res (px_n)
  );

  bpos_scale #(
    .IN_W (TOT_W + 1), .COEF_W (COEF_W), .FRAC (COEF_FRAC),
    .OFS_W (OFS_W), .OUT_W (OUT_W), .SUBTRACT (1'b0)
  ) u_scale_i (
    .val ($signed({1'b0, sum_all})), .gain (k_i), .ofs (o_i), .res (pi_n)
  );

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rat_y_q <= '0;
      rat_x_q <= '0;
      yinv_q  <= 1'b0;
      xinv_q  <= 1'b0;
      ovr_q   <= 1'b0;
      res_v_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rat_y_q <= rat_y_d;
      rat_x_q <= rat_x_d;
      yinv_q  <= yinv_d;
      xinv_q  <= xinv_d;
      ovr_q   <= ovr_d;
      res_v_q <= res_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
      d_q <= '0;
    end else if (accept) begin
      a_q <= amp_a;
      b_q <= amp_b;
      c_q <= amp_c;
      d_q <= amp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      py_q    <= '0;
      px_q    <= '0;
      pi_q    <= '0;
      oyinv_q <= 1'b0;
      oxinv_q <= 1'b0;
    end else if (out_en) begin
      py_q    <= py_n;
      px_q    <= px_n;
      pi_q    <= pi_n;
      oyinv_q <= yinv_q;
      oxinv_q <= xinv_q;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign res_valid = res_v_q;
  assign pos_y     = py_q;
  assign pos_x     = px_q;
  assign beam_cur  = pi_q;
  assign y_invalid = oyinv_q;
  assign x_invalid = oxinv_q;
  assign overrun   = ovr_q;

  assert_res_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy);
  assert_ovr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy) |=> overrun);
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_ratio_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_YWAIT) && div_done && (sum_ab != '0)) |-> (div_quo <= Q_ONE));
  assert_zero_den_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_YWAIT) && div_done && (sum_ab == '0)) |=>
      ((rat_y_q == '0) && yinv_q));
  assert_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_v_d) |=> ($stable(pos_x) && $stable(pos_y) && $stable(beam_cur)));
endmodule

// File: tb/bpos_calc_test.sv
`timescale 1ns/1ps
module bpos_calc_test;
  localparam int LAT = 39;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [17:0] amp_a, amp_b, amp_c, amp_d;
  logic cfg_we;
  logic [2:0] cfg_sel;
  logic [23:0] cfg_data;
  logic busy, res_valid, x_invalid, y_invalid, overrun;
  logic signed [23:0] pos_x, pos_y, beam_cur;

  always #2 clk = ~clk;

  bpos_calc uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .amp_a (amp_a), .amp_b (amp_b), .amp_c (amp_c), .amp_d (amp_d),
    .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_data (cfg_data),
    .busy (busy), .res_valid (res_valid), .pos_x (pos_x), .pos_y (pos_y),
    .beam_cur (beam_cur), .x_invalid (x_invalid), .y_invalid (y_invalid),
    .overrun (overrun)
  );

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";

  // reference model state
  int     cnt = 0;
  longint ma, mb, mc, md;
  longint kc[6];
  longint e_y = 0, e_x = 0, e_i = 0;
  bit     e_valid = 0, e_busy = 0, e_ovr = 0, e_yinv = 0, e_xinv = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s (%s) %s: got %0d expected %0d", req, tag, what, act, exp);
    end
  endtask

  function automatic longint sat24(input longint v);
    if (v > 64'sd8388607) return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  function automatic longint ratio(input longint p, input longint q, output bit inv);
    longint num, den, mag;
    num = p - q;
    den = p + q;
    if (den == 0) begin
      inv = 1'b1;
      return 0;
    end
    inv = 1'b0;
    mag = ((num < 0 ? -num : num) * 65536) / den;
    return (num < 0) ? -mag : mag;
  endfunction

  function automatic void produce();
    longint ry, rx;
    bit iy, ix;
    ry = ratio(ma, mb, iy);
    rx = ratio(mc, md, ix);
    e_y    = sat24(((kc[0] * ry) >>> 14) - kc[3]);
    e_x    = sat24(((kc[1] * rx) >>> 14) - kc[4]);
    e_i    = sat24(((kc[2] * (ma + mb + mc + md)) >>> 14) + kc[5]);
    e_yinv = iy;
    e_xinv = ix;
    e_valid = 1'b1;
  endfunction

  function automatic void model_edge(input bit iv, input longint a, b, c, d,
                                     input bit we, input int sel, input logic [23:0] data);
    e_valid = 1'b0;
    if (cnt > 0) begin
      if (iv) e_ovr = 1'b1;
      cnt--;
      if (cnt == 0) produce();
    end else if (iv) begin
      ma = a; mb = b; mc = c; md = d;
      cnt = LAT;
    end
    e_busy = (cnt > 0);
    if (we && sel < 3) kc[sel] = longint'($signed(data[15:0]));
    else if (we && sel < 6) kc[sel] = longint'($signed(data));
  endfunction

  task automatic compare_all();
    chk("R5", "res_valid", res_valid, e_valid);
    chk("R7", "busy", busy, e_busy);
    chk("R7", "overrun", overrun, e_ovr);
    chk("R2", "pos_y", pos_y, e_y);
    chk("R3", "pos_x", pos_x, e_x);
    chk("R4", "beam_cur", beam_cur, e_i);
    chk("R6", "y_invalid", y_invalid, e_yinv);
    chk("R6", "x_invalid", x_invalid, e_xinv);
  endtask

  task automatic cycle(input bit iv, input int a, b, c, d,
                       input bit we, input int sel, input int data);
    @(negedge clk);
    compare_all();
    in_valid = iv;
    amp_a = a[17:0]; amp_b = b[17:0]; amp_c = c[17:0]; amp_d = d[17:0];
    cfg_we = we; cfg_sel = sel[2:0]; cfg_data = data[23:0];
    model_edge(iv, a, b, c, d, we, sel, data[23:0]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic vec(input int a, b, c, d);
    cycle(1, a, b, c, d, 0, 0, 0);
    idle(LAT + 1);
  endtask

  task automatic wr(input int sel, input int data);
    cycle(0, 0, 0, 0, 0, 1, sel, data);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    kc[0] = 16384; kc[1] = 16384; kc[2] = 16384;
    kc[3] = 0; kc[4] = 0; kc[5] = 0;
    rst_n = 1'b0;
    in_valid = 0; amp_a = 0; amp_b = 0; amp_c = 0; amp_d = 0;
    cfg_we = 0; cfg_sel = 0; cfg_data = 0;
    repeat (3) @(posedge clk);
    #1;
    tag = "R1 reset";
    compare_all();
    @(negedge clk);
    rst_n = 1'b1;

    tag = "R1 defaults";
    vec(1000, 3000, 5000, 5000);      // unit gains, zero offsets
    tag = "R2 R3 basic";
    vec(40000, 10000, 7, 91234);
    vec(262143, 0, 0, 262143);        // ratios exactly +1.0 and -1.0
    vec(1, 2, 3, 1);
    tag = "R6 zero sum";
    vec(0, 0, 500, 100);
    vec(700, 100, 0, 0);
    vec(0, 0, 0, 0);

    tag = "R9 writes";
    wr(0, 'hC000);                    // KY = -1.0
    wr(1, 32767);                     // KX just under 2.0
    wr(2, 'h8000);                    // KI = -2.0
    wr(3, 12345);
    wr(4, -777);
    wr(5, 100000);
    vec(30000, 12000, 9000, 45000);
    vec(5, 250000, 260000, 3);
    tag = "R9 unused codes";
    wr(6, 'h7FFF);
    wr(7, 'h7FFFFF);
    vec(30000, 12000, 9000, 45000);

    tag = "R8 saturation";
    wr(2, 32767);
    wr(5, 8388607);
    wr(3, -8388608);
    wr(0, 32767);
    wr(4, 8388607);
    wr(1, 32767);
    vec(262143, 0, 0, 262143);
    wr(2, 'h8000);
    wr(5, -8388608);
    vec(262143, 262143, 262143, 262143);

    tag = "R7 overrun";
    wr(0, 16384); wr(1, -9000); wr(2, 20000);
    wr(3, 0); wr(4, 55); wr(5, -300);
    cycle(1, 1111, 2222, 3333, 4444, 0, 0, 0);
    idle(5);
    cycle(1, 99, 99, 99, 99, 0, 0, 0);      // dropped
    idle(LAT - 7);
    cycle(1, 5, 6, 7, 8, 0, 0, 0);          // arrives on the result edge: dropped
    idle(3);
    tag = "R7 continuous";
    for (int i = 0; i < 2 * LAT + 5; i++) cycle(1, 100 + i, 200, 300, 400 + 3 * i, 0, 0, 0);
    idle(LAT + 2);

    tag = "R2 R3 R4 mixed";
    for (int i = 0; i < 12; i++)
      vec($urandom_range(0, 262143), $urandom_range(0, 262143),
          $urandom_range(0, 4000), $urandom_range(0, 262143));

    idle(2);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule